// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked host and an external asynchronous static RAM with 65,536 words of 4 bits. The RAM has a 16-bit address, a 4-bit data-in path, a separate 4-bit data-out path, and active-low chip-enable and write-enable strobes. The host makes one request at a time. It raises `req` with the address, the write data and a write flag. The controller answers with a one-cycle `ack`, and for a read it also presents the word it fetched on `rd_data`.

Each timing minimum of the RAM is a parameter in nanoseconds. The controller turns each one into a whole number of clock cycles, rounding up. A write first selects the chip while write enable is still high, so the address and data are settled before the write begins. It then pulls write enable low for the pulse count. Write enable rises while chip enable is still low, so the write is always ended by write enable. Chip enable is released one or more cycles later. A read holds write enable high and chip enable low for the access count, then registers the output lines on the edge that ends that count.

The controller also tracks when the RAM's output lines are driven. The RAM floats its outputs whenever write enable is low or chip enable is high, and `mem_q_live` follows that.

Top module: `sram_timing_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `mem_ce_n` and `mem_we_n` are 1, and `ack`, `mem_q_live` and `rd_data` are 0.
- R2: A write request is accepted on a rising edge of the clock.
  - That edge drives `mem_addr` and `mem_din` and pulls `mem_ce_n` low, with `mem_we_n` still high.
  - On the next edge `mem_we_n` falls and stays low for the pulse count, which is 1 cycle at the defaults.
  - `mem_ce_n` rises together with `ack` once chip enable has been low for at least the write-cycle count.
  - At the defaults, chip enable is low for 3 cycles and `ack` is seen 4 cycles after the request is raised.
- R3: `mem_we_n` is never low while `mem_ce_n` is high. Every write ends with `mem_we_n` rising while `mem_ce_n` is still low.
- R4: `mem_addr` and `mem_din` do not change while `mem_ce_n` stays low. They keep their values after the write ends, until the next request is accepted.
- R5: A read request is accepted on an edge that pulls `mem_ce_n` low, while `mem_we_n` stays high for the whole read.
  - Chip enable stays low for the larger of the access count and the read-cycle count, which is 2 cycles at the defaults.
  - On the edge that ends that span, `rd_data` takes the value on `mem_dout` and `ack` rises.
  - At the defaults, `ack` is seen 3 cycles after the request is raised.
- R6: `ack` lasts exactly one cycle, and `mem_ce_n` is high during it.
  - No request is accepted in the cycle in which `ack` is high.
  - A request that is held high through the `ack` cycle is accepted one cycle later than a request raised while the controller is idle.
- R7: `mem_q_live` is 1 only in a cycle in which `mem_ce_n` is low and `mem_we_n` is high, and in which both were also true in the cycle before.
  - It is 0 in the cycle in which `mem_we_n` falls.
- R8: `rd_data` changes only when a read completes. A write leaves it unchanged.
- R9: Each timing count is ceil(ns / clock period), with a nonzero minimum always giving at least one cycle.
  - The write-enable pulse is at least the pulse-width count and at least the data-setup count.
  - On a read, chip enable is low for at least the access count before data is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, held by the host until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 4 | Data to write |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 4 | Word captured by the last read |
| mem_addr | output | 16 | RAM address lines |
| mem_din | output | 4 | RAM data-input lines |
| mem_dout | input | 4 | RAM data-output lines |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_q_live | output | 1 | 1 while the RAM output lines are known to be driven |

## Verification
The bench counts cycles from the clock edge that follows the moment the host raises `req`, and samples every output on the falling clock edge. At the defaults, a write's `ack` is due 4 cycles after `req` is raised and a read's `ack` 3 cycles after it; a request held high through an `ack` cycle is due one cycle later. Each request goes into a scoreboard queue with the cycle in which its `ack` is due. On every falling edge, the monitor works out the chip-enable and write-enable run lengths, the expected `mem_q_live`, and the expected hold on the address bus, all from the previous sampled cycle. `rd_data` is compared only in the `ack` cycle, and it must keep its old value after every write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WHOLD,
    ST_RACC
  } seq_state_e;

  // Nanoseconds to whole clock cycles, rounded up; zero stays zero.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    if (t_ns <= 0) return 0;
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int floor_one(input int a);
    return (a < 1) ? 1 : a;
  endfunction

endpackage

// File: rtl/sram_drive_track.sv
module sram_drive_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic q_live
);
  logic sel_now;
  logic sel_prev;

  assign sel_now = !ce_n && we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel_now;
  end

  // Outputs drive only after a full cycle of read selection.
  assign q_live = sel_prev && sel_now;

  AST_FLOAT_ON_WE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> !q_live); // R7
  AST_TURN_ON_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !q_live); // R7
  AST_LIVE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    q_live |-> (!ce_n && $past(!ce_n))); // R7
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_ev,
  input  logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)          rd_data <= '0;
    else if (capture_ev) rd_data <= mem_dout;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_ev |=> $stable(rd_data)); // R8
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 4,
  parameter int CNT_W     = 4,
  parameter int PULSE_CYC = 1,
  parameter int WC_CYC    = 2,
  parameter int RD_CYC    = 2,
  parameter int PWE_CYC   = 1,
  parameter int SD_CYC    = 1,
  parameter int AA_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ce_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] din,
  output logic              ack,
  output logic              accept_ev,
  output logic              capture_ev
);
  localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] WC_LIM    = CNT_W'(WC_CYC);
  localparam logic [CNT_W-1:0] RD_LIM    = CNT_W'(RD_CYC);
  localparam logic [CNT_W-1:0] CNT_SAT   = {CNT_W{1'b1}};

  seq_state_e       state;
  logic [CNT_W-1:0] el;   // completed chip-enable-low cycles
  logic [CNT_W-1:0] ph;   // completed write-enable-low cycles
  logic             finish_w;
  logic             finish_r;

  assign accept_ev  = (state == ST_IDLE) && req && !ack;
  assign finish_w   = (state == ST_WHOLD) && (el >= WC_LIM);
  assign finish_r   = (state == ST_RACC) && (el >= RD_LIM);
  assign capture_ev = finish_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      addr  <= '0;
      din   <= '0;
      el    <= '0;
      ph    <= '0;
      ack   <= 1'b0;
    end else begin
      ack <= finish_w || finish_r;
      if (state != ST_IDLE && el != CNT_SAT) el <= el + 1'b1;
      case (state)
        ST_IDLE: begin
          if (accept_ev) begin
            addr <= req_addr;
            if (req_we) din <= req_wdata;
            ce_n  <= 1'b0;
            el    <= CNT_W'(1);
            state <= req_we ? ST_WSET : ST_RACC;
          end
        end
        ST_WSET: begin
          we_n  <= 1'b0;
          ph    <= CNT_W'(1);
          state <= ST_WLOW;
        end
        ST_WLOW: begin
          if (ph >= PULSE_LIM) begin
            we_n  <= 1'b1;
            state <= ST_WHOLD;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_WHOLD: begin
          if (finish_w) begin
            ce_n  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_RACC: begin
          if (finish_r) begin
            ce_n  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent run-length counters used only by the checks below.
  logic [CNT_W-1:0] chk_we_run;
  logic [CNT_W-1:0] chk_ce_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_we_run <= '0;
      chk_ce_run <= '0;
    end else begin
      chk_we_run <= we_n ? '0 : ((chk_we_run == CNT_SAT) ? chk_we_run : chk_we_run + 1'b1);
      chk_ce_run <= ce_n ? '0 : ((chk_ce_run == CNT_SAT) ? chk_ce_run : chk_ce_run + 1'b1);
    end
  end

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n); // R3
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !ce_n); // R3
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(din))); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R6
  AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ce_n && we_n)); // R6
  AST_NO_ACCEPT_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !accept_ev); // R6
  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (chk_we_run >= CNT_W'(PWE_CYC) && chk_we_run >= CNT_W'(SD_CYC))); // R9
  AST_ACCESS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |-> ((chk_ce_run + 1'b1) >= CNT_W'(AA_CYC) && we_n)); // R9
endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 4,
  parameter int CLK_NS       = 10,
  parameter int T_WCYC_NS    = 12,
  parameter int T_WPULSE_NS  = 8,
  parameter int T_ASETUP_NS  = 9,
  parameter int T_DSETUP_NS  = 8,
  parameter int T_ACCESS_NS  = 12,
  parameter int T_RCYC_NS    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din,
  input  logic [DATA_W-1:0] mem_dout,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_q_live
);
  localparam int WC_CYC  = floor_one(ns_to_cyc(T_WCYC_NS, CLK_NS));
  localparam int PWE_CYC = floor_one(ns_to_cyc(T_WPULSE_NS, CLK_NS));
  localparam int SD_CYC  = floor_one(ns_to_cyc(T_DSETUP_NS, CLK_NS));
  localparam int AW_CYC  = floor_one(ns_to_cyc(T_ASETUP_NS, CLK_NS));
  localparam int AA_CYC  = floor_one(ns_to_cyc(T_ACCESS_NS, CLK_NS));
  localparam int RC_CYC  = floor_one(ns_to_cyc(T_RCYC_NS, CLK_NS));
  // Address is valid one setup cycle before write enable falls.
  localparam int PULSE_CYC = max_of(max_of(PWE_CYC, SD_CYC), floor_one(AW_CYC - 1));
  localparam int RD_CYC    = max_of(AA_CYC, RC_CYC);
  localparam int CNT_W     = $clog2(max_of(max_of(WC_CYC, RD_CYC), PULSE_CYC) + 2) + 1;

  logic accept_ev;
  logic capture_ev;

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .PULSE_CYC(PULSE_CYC), .WC_CYC(WC_CYC), .RD_CYC(RD_CYC),
    .PWE_CYC(PWE_CYC), .SD_CYC(SD_CYC), .AA_CYC(AA_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .addr(mem_addr), .din(mem_din),
    .ack(ack), .accept_ev(accept_ev), .capture_ev(capture_ev)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture_ev(capture_ev),
    .mem_dout(mem_dout), .rd_data(rd_data)
  );

  sram_drive_track u_track (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .we_n(mem_we_n), .q_live(mem_q_live)
  );

  AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> (mem_ce_n && mem_we_n)); // R6
  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (!mem_ce_n && mem_we_n)); // R2
endmodule

// File: tb/tb_sram_timing_ctrl.sv
module tb_sram_timing_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        ack;
  logic [3:0]  rd_data;
  logic [15:0] mem_addr;
  logic [3:0]  mem_din;
  logic [3:0]  mem_dout = 4'bz;
  logic        mem_ce_n;
  logic        mem_we_n;
  logic        mem_q_live;

  always #5 clk = ~clk;

  sram_timing_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_din(mem_din), .mem_dout(mem_dout),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_q_live(mem_q_live)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("%s %s actual=%0h expected=%0h", "FAIL", rq, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // RAM model, contents that were never written follow a fixed pattern.
  logic [3:0] ram [int unsigned];
  logic [3:0] expm [int unsigned];
  function automatic logic [3:0] seed_val(input logic [15:0] a);
    return a[3:0] ^ a[11:8] ^ 4'h5;
  endfunction

  typedef struct {
    bit          we;
    logic [15:0] a;
    logic [3:0]  d;
    logic [3:0]  exp_rd;
    int          due;
  } item_t;
  item_t sb[$];

  // Monitor: RAM model, protocol checks and scoreboard.
  logic        p_ce_n = 1'b1, p_we_n = 1'b1, p_sel = 1'b0;
  logic [15:0] p_addr = '0;
  logic [3:0]  p_din = '0;
  logic [3:0]  last_rd = '0;
  int          we_run = 0, ce_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_we_n && !p_ce_n && (mem_we_n || mem_ce_n))
        ram[p_addr] = p_din;
      if (!mem_we_n)
        chk(!mem_ce_n, "R3 ce low during we low", mem_ce_n, 0);
      if (!p_we_n && mem_we_n) begin
        chk(we_run == 1, "R2 we pulse length", we_run, 1);
        chk(!mem_ce_n, "R3 write ended by we", mem_ce_n, 0);
      end
      if (!p_ce_n && !mem_ce_n) begin
        chk(mem_addr == p_addr, "R4 addr held", mem_addr, p_addr);
        chk(mem_din == p_din, "R4 din held", mem_din, p_din);
      end
      if (p_ce_n && mem_ce_n && !ack) begin
        chk(mem_addr == p_addr, "R4 addr held after cycle", mem_addr, p_addr);
      end
      chk(mem_q_live == (p_sel && !mem_ce_n && mem_we_n), "R7 output drive tracking",
          mem_q_live, p_sel && !mem_ce_n && mem_we_n);
      if (p_we_n && !mem_we_n)
        chk(!mem_q_live, "R7 float on we fall", mem_q_live, 0);
      if (ack) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected ack", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(cyc == it.due, it.we ? "R2 write ack cycle" : "R5 read ack cycle", cyc, it.due);
          chk(mem_ce_n, "R6 ce high in ack cycle", mem_ce_n, 1);
          chk(ce_run == (it.we ? 3 : 2), it.we ? "R2 ce low span" : "R5 ce low span",
              ce_run, it.we ? 3 : 2);
          chk(mem_addr == it.a, "R4 addr of request", mem_addr, it.a);
          if (it.we) begin
            chk(mem_din == it.d, "R4 din of request", mem_din, it.d);
            chk(rd_data == last_rd, "R8 rd_data kept over write", rd_data, last_rd);
          end else begin
            chk(rd_data == it.exp_rd, "R5 read data", rd_data, it.exp_rd);
            chk(we_run == 0 && mem_we_n, "R5 we high in read", we_run, 0);
            last_rd = rd_data;
          end
        end
      end
      if (p_ack_seen && ack) chk(1'b0, "R6 ack longer than one cycle", 1, 0);
      p_ack_seen = ack;
      we_run = mem_we_n ? 0 : we_run + 1;
      if (!mem_ce_n && p_ce_n) ce_run = 1;
      else if (!mem_ce_n) ce_run = ce_run + 1;
      else if (!ack) ce_run = 0;
      mem_dout = (!mem_ce_n && mem_we_n) ?
                 (ram.exists(mem_addr) ? ram[mem_addr] : seed_val(mem_addr)) : 4'bz;
    end
    p_ce_n = mem_ce_n;
    p_we_n = mem_we_n;
    p_sel  = !mem_ce_n && mem_we_n;
    p_addr = mem_addr;
    p_din  = mem_din;
  end
  bit p_ack_seen = 1'b0;

  // Driver: called at a falling edge, pushes the expected item.
  task automatic do_req(input bit we, input logic [15:0] a, input logic [3:0] d);
    item_t it;
    it.we = we;
    it.a  = a;
    it.d  = d;
    it.exp_rd = expm.exists(a) ? expm[a] : seed_val(a);
    it.due = cyc + (ack ? 1 : 0) + (we ? 4 : 3);
    if (we) expm[a] = d;
    sb.push_back(it);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!ack);
  endtask

  task automatic idle(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n, "R1 strobes high in reset", {mem_ce_n, mem_we_n}, 3);
    chk(!ack && !mem_q_live, "R1 ack and live low in reset", {ack, mem_q_live}, 0);
    chk(rd_data == 4'h0, "R1 rd_data cleared", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && !ack, "R1 idle after reset", {mem_ce_n, mem_we_n, ack}, 6);
    do_req(1'b1, 16'h0000, 4'h5);  idle(2);
    do_req(1'b1, 16'hFFFF, 4'hA);  idle(1);
    do_req(1'b0, 16'hFFFF, 4'h0);  idle(1);   // R5 top address
    do_req(1'b0, 16'h1234, 4'h0);  idle(3);   // R5 unwritten word
    do_req(1'b1, 16'h1234, 4'h3);             // R6 back-to-back, held req
    do_req(1'b0, 16'h1234, 4'h0);
    do_req(1'b1, 16'h0000, 4'hC);             // R8 write after read
    do_req(1'b0, 16'h0000, 4'h0);  idle(2);
    for (int i = 0; i < 24; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h2F31 + 16'h0101);
      do_req(1'b1, a, 4'(i * 7 + 3));
      if (i % 3 == 0) idle(1);
      do_req(1'b0, a, 4'h0);
      if (i % 2 == 1) idle(2);
    end
    idle(4);
    chk(sb.size() == 0, "R6 every request acknowledged", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R6 watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule